// File: doc/BRIEF.md
# UART interrupt identification controller

This block sits beside a simple serial port and turns four event sources into a single interrupt request. The four sources are line errors, received data waiting, the transmit holding register going empty, and modem line changes. Software enables each source on its own. It reads an identification register that names the one source, among those enabled and pending, with the highest priority. Each source then clears by its own rule.

The transmit-empty source is edge-like: it is raised when the holding register becomes empty, or when its enable is turned on while the register is already empty. It is dropped by a write of the next character, or by a read of the identification register that reports it. That read acts as the acknowledge, so a driver with nothing left to send can leave transmit interrupts enabled. The serial shifters, baud timing and FIFOs live elsewhere. The datapath supplies `rx_ready` and `tx_empty` as levels, and `line_err` and `modem_chg` as event strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `irq` is 0, the enable register (address 1) reads 0x00 and the identification register (address 2) reads 0x01.
- R2: Register map, read through `rdata` combinationally from `addr`: address 0 write is the transmit-holding write; address 1 is the enable register (bit0 receive, bit1 transmit-empty, bit2 line, bit3 modem); address 2 is identification; address 5 is line status (bit0 `rx_ready`, bit1 line error pending, bit5 `tx_empty`); address 6 is modem status (bit0 modem change pending). Other addresses read 0.
- R3: Identification bit0 is 1 when no enabled source is pending, else 0. Bits 2:1 give the type of the highest-priority enabled pending source: 11 line, 10 receive, 01 transmit-empty, 00 modem. Priority runs in that order from highest to lowest.
- R4: The receive source follows `rx_ready` as a level and is removed when `rx_ready` falls.
- R5: A rising edge of `tx_empty` sets the transmit-empty pending flag.
- R6: A write that changes the transmit enable from 0 to 1 while `tx_empty` is 1 sets the transmit-empty pending flag.
- R7: A write to address 0 clears the transmit-empty pending flag.
- R8: A read (`rd_en`) of address 2 that returns transmit-empty type clears that flag. The next pending source is then reported.
- R9: A `line_err` strobe sets a sticky line flag, which a read of address 5 clears.
- R10: A `modem_chg` strobe sets a sticky modem flag, which a read of address 6 clears.
- R11: `irq` is registered. It is 1 in the cycle after any enabled source is pending and 0 in the cycle after none is.
- R12: The enables are independent: clearing the transmit enable leaves receive interrupts active.
- R13: A pending source whose enable is off is neither reported nor drives `irq`. It stays pending and appears once enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rx_ready | input | 1 | Received character waiting (level) |
| tx_empty | input | 1 | Transmit holding register empty (level) |
| line_err | input | 1 | Line error event strobe |
| modem_chg | input | 1 | Modem line change event strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench raises all four sources at once and works down the priority order. It checks that each clear uncovers the next source: a design with the wrong order, or a clear rule tied to the wrong register, would report the wrong type at some step. It checks that an identification read reporting transmit-empty drops the request, while peeking the register without a read strobe leaves it pending. A design that acknowledged on every read, or on none, would leave `irq` wrong. It also checks two further cases. Enabling the transmit source while the holding register is already empty must raise a request with no edge on `tx_empty`. A source that is pending but disabled must stay hidden until it is re-enabled.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int A_DATA   = 0,
  parameter int A_ENABLE = 1,
  parameter int A_IDENT  = 2,
  parameter int A_LSTAT  = 5,
  parameter int A_MSTAT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_ready,
  input  logic              tx_empty,
  input  logic              line_err,
  input  logic              modem_chg,
  output logic              irq
);

  logic [3:0] en;
  logic       line_p, tx_p, mdm_p, tx_empty_q;
  logic [3:0] act;
  logic [2:0] ident;

  wire sel_data  = addr == ADDR_W'(A_DATA);
  wire sel_en    = addr == ADDR_W'(A_ENABLE);
  wire sel_ident = addr == ADDR_W'(A_IDENT);
  wire sel_lstat = addr == ADDR_W'(A_LSTAT);
  wire sel_mstat = addr == ADDR_W'(A_MSTAT);

  assign act = {mdm_p & en[3], line_p & en[2], tx_p & en[1], rx_ready & en[0]};

  always_comb begin
    if (act[2])      ident = 3'b110;
    else if (act[0]) ident = 3'b100;
    else if (act[1]) ident = 3'b010;
    else if (act[3]) ident = 3'b000;
    else             ident = 3'b001;
  end

  wire tx_set = (tx_empty & ~tx_empty_q) |
                (wr_en & sel_en & wdata[1] & ~en[1] & tx_empty);
  wire tx_clr = (wr_en & sel_data) | (rd_en & sel_ident & ident == 3'b010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= '0;
      line_p     <= 1'b0;
      tx_p       <= 1'b0;
      mdm_p      <= 1'b0;
      tx_empty_q <= 1'b1;
      irq        <= 1'b0;
    end else begin
      tx_empty_q <= tx_empty;
      irq        <= |act;
      if (wr_en && sel_en) en <= wdata[3:0];
      if (tx_set)      tx_p <= 1'b1;
      else if (tx_clr) tx_p <= 1'b0;
      if (line_err)                 line_p <= 1'b1;
      else if (rd_en && sel_lstat)  line_p <= 1'b0;
      if (modem_chg)                mdm_p <= 1'b1;
      else if (rd_en && sel_mstat)  mdm_p <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_en)    rdata[3:0] = en;
    if (sel_ident) rdata[2:0] = ident;
    if (sel_lstat) begin
      rdata[0] = rx_ready;
      rdata[1] = line_p;
      rdata[5] = tx_empty;
    end
    if (sel_mstat) rdata[0] = mdm_p;
  end

  // R8
  tx_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_ident && rdata[2:0] == 3'b010 && !tx_set) |=> !tx_p);

  // R3
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_p && en[2]) |-> (rdata[2:0] == 3'b110 || !sel_ident));

  // R11
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 4'b0) |=> !irq);

  // R5
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |=> tx_p);

  // R9
  line_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_p && !(rd_en && sel_lstat)) |=> line_p);

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic rx_ready = 0, tx_empty = 1, line_err = 0, modem_chg = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_ident u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rx_ready(rx_ready),
    .tx_empty(tx_empty), .line_err(line_err), .modem_chg(modem_chg), .irq(irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; rd_en = 1; #1 chk(tag, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; #1 chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'b0, irq}, 8'h00);
    peek(1, 8'h00, "R1 enable");
    peek(2, 8'h01, "R1 ident");
    peek(5, 8'h20, "R2 status");
  endtask

  task automatic t_rx();
    wr(1, 8'h01);
    @(negedge clk); rx_ready = 1;
    settle();
    chk("R11 irq rx", {7'b0, irq}, 8'h01);
    peek(2, 8'h04, "R4 ident rx");
    @(negedge clk); rx_ready = 0;
    settle();
    chk("R4 irq drop", {7'b0, irq}, 8'h00);
    peek(2, 8'h01, "R4 ident idle");
  endtask

  task automatic t_tx_enable();
    wr(1, 8'h02);
    settle();
    chk("R6 irq", {7'b0, irq}, 8'h01);
    peek(2, 8'h02, "R6 ident");
    settle();
    chk("R8 peek keeps", {7'b0, irq}, 8'h01);
    rd(2, 8'h02, "R8 ack read");
    settle();
    chk("R8 irq drop", {7'b0, irq}, 8'h00);
    peek(2, 8'h01, "R8 ident idle");
  endtask

  task automatic t_tx_rise();
    pulse_tx();
    settle();
    chk("R5 irq", {7'b0, irq}, 8'h01);
    peek(2, 8'h02, "R5 ident");
    wr(0, 8'h41);
    settle();
    chk("R7 irq", {7'b0, irq}, 8'h00);
    peek(2, 8'h01, "R7 ident");
  endtask

  task automatic t_priority();
    wr(1, 8'h0F);
    @(negedge clk); modem_chg = 1;
    @(negedge clk); modem_chg = 0;
    peek(2, 8'h00, "R10 modem alone");
    pulse_tx();
    @(negedge clk); rx_ready = 1; line_err = 1;
    @(negedge clk); line_err = 0;
    peek(2, 8'h06, "R3 line top");
    settle();
    peek(2, 8'h06, "R9 line sticky");
    rd(5, 8'h23, "R9 status read");
    peek(2, 8'h04, "R3 rx next");
    @(negedge clk); rx_ready = 0;
    peek(2, 8'h02, "R3 tx next");
    rd(2, 8'h02, "R8 ack");
    peek(2, 8'h00, "R8 modem next");
    settle();
    chk("R11 irq modem", {7'b0, irq}, 8'h01);
    rd(6, 8'h01, "R10 modem read");
    peek(6, 8'h00, "R10 cleared");
    settle();
    chk("R11 irq idle", {7'b0, irq}, 8'h00);
    peek(2, 8'h01, "R3 idle");
  endtask

  task automatic t_indep();
    wr(1, 8'h03);
    pulse_tx();
    @(negedge clk); rx_ready = 1;
    peek(2, 8'h04, "R12 rx over tx");
    wr(1, 8'h01);
    settle();
    chk("R12 irq rx stays", {7'b0, irq}, 8'h01);
    peek(2, 8'h04, "R12 ident rx");
    @(negedge clk); rx_ready = 0;
    settle();
    chk("R13 hidden irq", {7'b0, irq}, 8'h00);
    peek(2, 8'h01, "R13 hidden ident");
    wr(1, 8'h02);
    peek(2, 8'h02, "R13 reappears");
    rd(2, 8'h02, "R8 final ack");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_rx(); t_tx_enable(); t_tx_rise(); t_priority(); t_indep();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule